// File: doc/BRIEF.md
# Fault Escalation Unit

This block sits beside an exception controller and decides what becomes of each fault event reported to it. Three fault classes arrive as single-cycle strobes: memory-protection violations, bus errors carrying a cause code, and usage errors carrying a cause code. A separate strobe reports a bus error during a vector fetch. For each class strobe the unit does one of two things. It can hold the fault pending and later raise a request for that class's own handler. Otherwise it escalates the fault to a hard fault.

A fault is escalated when its class is disabled, or when a handler whose priority number is equal or lower (more urgent) is already running. A vector-fetch error always becomes a hard fault. An enabled fault is held pending while a more urgent exception is arriving. It is released once nothing more urgent blocks it. Every cause is recorded in sticky status registers, which software clears by writing ones. A small write port also sets the three class enable bits.

The output stage is a three-state machine. QUIET raises no request. HARD drives the hard-fault request for one cycle. TAKE drives the fault request and its class code for one cycle. Each cycle the next state is chosen from three cases. Any escalation leads to HARD. Otherwise a ready pending fault leads to TAKE, which removes that fault from pending. Otherwise the next state is QUIET. Every state can move to every other state.

Top module: `fault_escalator`

## Requirements
- R1: After reset, hf_req and fault_req are 0, and all status and enable bits are 0.
- R2: A class strobe whose enable bit is 0 gives hf_req in the next cycle and sets hf_stat bit 1 (forced). The enable bits are flt_en bit 0 = memory, bit 1 = bus and bit 2 = usage.
- R3: An enabled class strobe gives the same escalation as R2 when run_vld is 1 and the class priority number is greater than or equal to cur_pri.
- R4: An enabled, unescalated fault stays pending with no request while arr_vld is 1 and arr_pri is lower than the class priority number. It is requested one cycle after that condition clears.
- R5: With nothing blocking, an enabled fault gives fault_req two cycles after its strobe. fault_type is then 0 for memory, 1 for bus and 2 for usage.
- R6: vec_err always gives hf_req in the next cycle, whatever the enable bits. It also sets hf_stat bit 0 and bus_stat bit 4.
- R7: A bus strobe sets bus_stat bit bus_cause. The codes are 0 instruction prefetch, 1 data access, 2 stacking and 3 unstacking.
- R8: A usage strobe sets usg_stat bit usg_cause. Codes 0 to 4 are undefined instruction, coprocessor, invalid state, invalid return and unaligned multiple. Code 5 (divide by zero) counts only when div0_trap is 1, and code 6 (unaligned) only when unal_trap is 1. A code that does not count, and code 7, changes nothing and raises nothing.
- R9: A write with wr_sel 1 (bus), 2 (memory, data bit 0), 3 (usage) or 4 (hard fault) clears the status bits where wr_data is 1. Bits written 0 keep their value. A set in the same cycle wins over a clear.
- R10: Strobes that arrive together are all recorded, and at most one of hf_req or fault_req is high in any cycle. HARD takes precedence, and pending faults are taken in the order memory, bus, usage.
- R11: A write with wr_sel 0 loads flt_en from wr_data[2:0]. The new value is used from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_vld | input | 1 | Bus error strobe |
| bus_cause | input | 2 | Bus error cause code |
| vec_err | input | 1 | Bus error during vector fetch |
| mem_vld | input | 1 | Memory-protection violation strobe |
| usg_vld | input | 1 | Usage error strobe |
| usg_cause | input | 3 | Usage error cause code |
| div0_trap | input | 1 | Allow divide-by-zero usage faults |
| unal_trap | input | 1 | Allow unaligned-access usage faults |
| mem_pri | input | PRI_W | Memory fault priority number |
| bus_pri | input | PRI_W | Bus fault priority number |
| usg_pri | input | PRI_W | Usage fault priority number |
| run_vld | input | 1 | A handler is executing |
| cur_pri | input | PRI_W | Priority number of the executing handler |
| arr_vld | input | 1 | Another exception is arriving |
| arr_pri | input | PRI_W | Priority number of the arriving exception |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | 8 | Write data |
| hf_req | output | 1 | Hard-fault request |
| fault_req | output | 1 | Class fault request |
| fault_type | output | 2 | Class of the fault request |
| flt_en | output | 3 | Class enable bits |
| bus_stat | output | 5 | Sticky bus cause bits |
| mem_stat | output | 1 | Sticky memory violation bit |
| usg_stat | output | 7 | Sticky usage cause bits |
| hf_stat | output | 2 | Sticky hard-fault bits: 0 vector, 1 forced |

## Verification
Directed runs come first. A disabled class separates escalation by enable from escalation by priority. The running priority is then set equal to the fault priority and one step below it, which probes the exact edge of the comparison. A held arrival separates pending from taken. Untrapped divide-by-zero and unaligned codes show that ignored causes change nothing. Three simultaneous strobes show the take order, and an escalation mixed with a pended fault shows that HARD goes first. A long random phase then mixes strobes, writes and priority changes. A behavioural model checks every output on every clock.

// File: rtl/fe_pkg.sv
package fe_pkg;
    localparam int NCLS  = 3;
    localparam int BUS_W = 5;
    localparam int USG_W = 7;

    typedef enum logic [1:0] {
        CLS_MEM = 2'd0,
        CLS_BUS = 2'd1,
        CLS_USG = 2'd2
    } fcls_t;

    typedef enum logic [1:0] {
        ST_QUIET = 2'd0,
        ST_HARD  = 2'd1,
        ST_TAKE  = 2'd2
    } fst_t;

    localparam logic [2:0] SEL_EN   = 3'd0;
    localparam logic [2:0] SEL_BUS  = 3'd1;
    localparam logic [2:0] SEL_MEM  = 3'd2;
    localparam logic [2:0] SEL_USG  = 3'd3;
    localparam logic [2:0] SEL_HARD = 3'd4;
endpackage

// File: rtl/fe_sticky.sv
module fe_sticky #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_en,
    input  logic [W-1:0] clr_mask,
    input  logic [W-1:0] set_mask,
    output logic [W-1:0] q
);
    logic [W-1:0] clr_eff;
    assign clr_eff = clr_en ? clr_mask : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr_eff) | set_mask;
    end
endmodule

// File: rtl/fe_usage_decode.sv
module fe_usage_decode #(
    parameter int USG_W = 7
) (
    input  logic             vld,
    input  logic [2:0]       cause,
    input  logic             div0_trap,
    input  logic             unal_trap,
    output logic [USG_W-1:0] set_mask,
    output logic             hit
);
    always_comb begin
        set_mask = '0;
        if (vld) begin
            unique case (cause)
                3'd5:    set_mask[5] = div0_trap;
                3'd6:    set_mask[6] = unal_trap;
                3'd7:    set_mask = '0;
                default: set_mask[cause] = 1'b1;
            endcase
        end
    end
    assign hit = |set_mask;
endmodule

// File: rtl/fe_judge.sv
module fe_judge #(
    parameter int PRI_W = 4
) (
    input  logic             hit,
    input  logic             en,
    input  logic             pend,
    input  logic [PRI_W-1:0] pri,
    input  logic             run_vld,
    input  logic [PRI_W-1:0] cur_pri,
    input  logic             arr_vld,
    input  logic [PRI_W-1:0] arr_pri,
    output logic             esc,
    output logic             pend_set,
    output logic             ready
);
    logic run_blocks;
    logic arr_blocks;

    assign run_blocks = run_vld && (pri >= cur_pri);
    assign arr_blocks = arr_vld && (arr_pri < pri);

    assign esc      = hit && (!en || run_blocks);
    assign pend_set = hit && en && !run_blocks;
    assign ready    = pend && en && !run_blocks && !arr_blocks;
endmodule

// File: rtl/fault_escalator.sv
module fault_escalator
    import fe_pkg::*;
#(
    parameter int PRI_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_vld,
    input  logic [1:0]       bus_cause,
    input  logic             vec_err,
    input  logic             mem_vld,
    input  logic             usg_vld,
    input  logic [2:0]       usg_cause,
    input  logic             div0_trap,
    input  logic             unal_trap,
    input  logic [PRI_W-1:0] mem_pri,
    input  logic [PRI_W-1:0] bus_pri,
    input  logic [PRI_W-1:0] usg_pri,
    input  logic             run_vld,
    input  logic [PRI_W-1:0] cur_pri,
    input  logic             arr_vld,
    input  logic [PRI_W-1:0] arr_pri,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [7:0]       wr_data,
    output logic             hf_req,
    output logic             fault_req,
    output logic [1:0]       fault_type,
    output logic [2:0]       flt_en,
    output logic [4:0]       bus_stat,
    output logic             mem_stat,
    output logic [6:0]       usg_stat,
    output logic [1:0]       hf_stat
);
    logic [USG_W-1:0]   usg_set;
    logic               usg_hit;
    logic [NCLS-1:0]    hit;
    logic [NCLS-1:0]    esc;
    logic [NCLS-1:0]    pend_set;
    logic [NCLS-1:0]    ready;
    logic [NCLS-1:0]    pend_q;
    logic [NCLS-1:0]    en_q;
    logic [NCLS-1:0]    take_clr;
    logic [PRI_W-1:0]   pri_arr [NCLS];
    logic               esc_any;
    logic               take_vld;
    fcls_t              take_cls;
    fcls_t              type_q;
    fst_t               state_q;
    fst_t               state_d;
    logic [BUS_W-1:0]   bus_set;
    logic [BUS_W-1:0]   bus_cause_hot;

    fe_usage_decode #(.USG_W(USG_W)) u_usg_dec (
        .vld       (usg_vld),
        .cause     (usg_cause),
        .div0_trap (div0_trap),
        .unal_trap (unal_trap),
        .set_mask  (usg_set),
        .hit       (usg_hit)
    );

    assign hit[CLS_MEM] = mem_vld;
    assign hit[CLS_BUS] = bus_vld;
    assign hit[CLS_USG] = usg_hit;
    assign pri_arr[CLS_MEM] = mem_pri;
    assign pri_arr[CLS_BUS] = bus_pri;
    assign pri_arr[CLS_USG] = usg_pri;

    for (genvar g = 0; g < NCLS; g++) begin : g_judge
        fe_judge #(.PRI_W(PRI_W)) u_judge (
            .hit      (hit[g]),
            .en       (en_q[g]),
            .pend     (pend_q[g]),
            .pri      (pri_arr[g]),
            .run_vld  (run_vld),
            .cur_pri  (cur_pri),
            .arr_vld  (arr_vld),
            .arr_pri  (arr_pri),
            .esc      (esc[g]),
            .pend_set (pend_set[g]),
            .ready    (ready[g])
        );
    end

    assign esc_any = (|esc) || vec_err;

    // fixed take order: lowest class code wins
    always_comb begin
        take_vld = 1'b0;
        take_cls = CLS_MEM;
        for (int i = NCLS - 1; i >= 0; i--) begin
            if (ready[i]) begin
                take_vld = 1'b1;
                take_cls = fcls_t'(2'(i));
            end
        end
    end

    // next-state selection
    always_comb begin
        if (esc_any)       state_d = ST_HARD;
        else if (take_vld) state_d = ST_TAKE;
        else               state_d = ST_QUIET;
    end

    always_comb begin
        take_clr = '0;
        if (state_d == ST_TAKE) take_clr[take_cls] = 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
            type_q  <= CLS_MEM;
        end else begin
            state_q <= state_d;
            if (state_d == ST_TAKE) type_q <= take_cls;
        end
    end

    // outputs
    always_comb begin
        hf_req     = 1'b0;
        fault_req  = 1'b0;
        fault_type = 2'd0;
        unique case (state_q)
            ST_QUIET: ;
            ST_HARD:  hf_req = 1'b1;
            ST_TAKE: begin
                fault_req  = 1'b1;
                fault_type = type_q;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~take_clr) | pend_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          en_q <= '0;
        else if (wr_en && wr_sel == SEL_EN)  en_q <= wr_data[NCLS-1:0];
    end
    assign flt_en = en_q;

    assign bus_cause_hot = bus_vld ? (BUS_W'(1) << bus_cause) : '0;
    assign bus_set       = bus_cause_hot | {vec_err, {(BUS_W-1){1'b0}}};

    fe_sticky #(.W(BUS_W)) u_bus_stat (
        .clk (clk), .rst_n (rst_n),
        .clr_en   (wr_en && wr_sel == SEL_BUS),
        .clr_mask (wr_data[BUS_W-1:0]),
        .set_mask (bus_set),
        .q        (bus_stat)
    );

    fe_sticky #(.W(1)) u_mem_stat (
        .clk (clk), .rst_n (rst_n),
        .clr_en   (wr_en && wr_sel == SEL_MEM),
        .clr_mask (wr_data[0]),
        .set_mask (mem_vld),
        .q        (mem_stat)
    );

    fe_sticky #(.W(USG_W)) u_usg_stat (
        .clk (clk), .rst_n (rst_n),
        .clr_en   (wr_en && wr_sel == SEL_USG),
        .clr_mask (wr_data[USG_W-1:0]),
        .set_mask (usg_set),
        .q        (usg_stat)
    );

    fe_sticky #(.W(2)) u_hf_stat (
        .clk (clk), .rst_n (rst_n),
        .clr_en   (wr_en && wr_sel == SEL_HARD),
        .clr_mask (wr_data[1:0]),
        .set_mask ({|esc, vec_err}),
        .q        (hf_stat)
    );

    a_r10_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        !(hf_req && fault_req));

    a_r6_vector_hard: assert property (@(posedge clk) disable iff (!rst_n)
        vec_err |=> (hf_req && hf_stat[0] && bus_stat[4]));

    a_r2_disabled_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_vld && !flt_en[0]) |=> (hf_req && hf_stat[1]));

    a_r3_running_blocks_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vld && run_vld && bus_pri >= cur_pri) |=> (hf_req && hf_stat[1]));

    a_r9_usage_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_USG && !usg_vld)
        |=> (usg_stat == ($past(usg_stat) & ~$past(wr_data[6:0]))));

    a_r8_div0_untrapped: assert property (@(posedge clk) disable iff (!rst_n)
        (usg_vld && usg_cause == 3'd5 && !div0_trap && !wr_en) |=> $stable(usg_stat));
endmodule

// File: tb/test_fault_escalator.sv
module test_fault_escalator;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_vld = 0, vec_err = 0, mem_vld = 0, usg_vld = 0;
    logic [1:0] bus_cause = 0;
    logic [2:0] usg_cause = 0;
    logic       div0_trap = 0, unal_trap = 0;
    logic [3:0] mem_pri = 0, bus_pri = 0, usg_pri = 0, cur_pri = 0, arr_pri = 0;
    logic       run_vld = 0, arr_vld = 0;
    logic       wr_en = 0;
    logic [2:0] wr_sel = 0;
    logic [7:0] wr_data = 0;
    logic       hf_req, fault_req;
    logic [1:0] fault_type;
    logic [2:0] flt_en;
    logic [4:0] bus_stat;
    logic       mem_stat;
    logic [6:0] usg_stat;
    logic [1:0] hf_stat;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_on = 0;

    always #4 clk = ~clk;

    fault_escalator #(.PRI_W(4)) i_fault_escalator (
        .clk, .rst_n, .bus_vld, .bus_cause, .vec_err, .mem_vld, .usg_vld, .usg_cause,
        .div0_trap, .unal_trap, .mem_pri, .bus_pri, .usg_pri, .run_vld, .cur_pri,
        .arr_vld, .arr_pri, .wr_en, .wr_sel, .wr_data, .hf_req, .fault_req,
        .fault_type, .flt_en, .bus_stat, .mem_stat, .usg_stat, .hf_stat
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_hf, m_fr, m_ft, m_en, m_bus, m_mem, m_usg, m_hfs;
    int m_pend[3];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hf = 0; m_fr = 0; m_ft = 0; m_en = 0;
            m_bus = 0; m_mem = 0; m_usg = 0; m_hfs = 0;
            foreach (m_pend[k]) m_pend[k] = 0;
        end else begin
            int pri[3];
            int hitc[3];
            int newp[3];
            int esc;
            int taken;
            pri[0] = mem_pri; pri[1] = bus_pri; pri[2] = usg_pri;
            hitc[0] = mem_vld; hitc[1] = bus_vld; hitc[2] = 0;
            newp[0] = 0; newp[1] = 0; newp[2] = 0;
            esc = 0;
            if (wr_en) begin
                case (wr_sel)
                    3'd1: m_bus = m_bus & ~int'(wr_data[4:0]);
                    3'd2: if (wr_data[0]) m_mem = 0;
                    3'd3: m_usg = m_usg & ~int'(wr_data[6:0]);
                    3'd4: m_hfs = m_hfs & ~int'(wr_data[1:0]);
                    default: ;
                endcase
            end
            if (vec_err) begin esc = 1; m_hfs |= 1; m_bus |= 16; end
            if (bus_vld) m_bus |= (1 << bus_cause);
            if (mem_vld) m_mem = 1;
            if (usg_vld) begin
                if (usg_cause < 5 || (usg_cause == 5 && div0_trap) || (usg_cause == 6 && unal_trap)) begin
                    m_usg |= (1 << usg_cause);
                    hitc[2] = 1;
                end
            end
            for (int c = 0; c < 3; c++) begin
                if (hitc[c] != 0) begin
                    if (((m_en >> c) & 1) == 0 || (run_vld && pri[c] >= cur_pri)) begin
                        esc = 1; m_hfs |= 2;
                    end else newp[c] = 1;
                end
            end
            m_hf = 0; m_fr = 0;
            if (esc != 0) m_hf = 1;
            else begin
                taken = 0;
                for (int c = 0; c < 3; c++) begin
                    if (taken == 0 && m_pend[c] != 0 && ((m_en >> c) & 1) != 0
                        && !(run_vld && pri[c] >= cur_pri) && !(arr_vld && arr_pri < pri[c])) begin
                        taken = 1; m_fr = 1; m_ft = c; m_pend[c] = 0;
                    end
                end
            end
            for (int c = 0; c < 3; c++) if (newp[c] != 0) m_pend[c] = 1;
            if (wr_en && wr_sel == 3'd0) m_en = wr_data[2:0];
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R2/R3/R6 hf_req", hf_req, m_hf);
            chk("R4/R5 fault_req", fault_req, m_fr);
            if (m_fr != 0) chk("R5 fault_type", fault_type, m_ft);
            chk("R10 one request", int'(hf_req && fault_req), 0);
            chk("R11 flt_en", flt_en, m_en);
            chk("R7 bus_stat", bus_stat, m_bus);
            chk("R9 mem_stat", mem_stat, m_mem);
            chk("R8 usg_stat", usg_stat, m_usg);
            chk("R2 hf_stat", hf_stat, m_hfs);
        end
    end

    task automatic idle();
        bus_vld = 0; vec_err = 0; mem_vld = 0; usg_vld = 0; wr_en = 0;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            idle();
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
        step(1);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 hf_req", hf_req, 0);
        chk("R1 fault_req", fault_req, 0);
        chk("R1 status", int'({bus_stat, mem_stat, usg_stat, hf_stat, flt_en}), 0);
        cmp_on = 1;

        // R2 disabled memory class escalates
        mem_pri = 4; bus_pri = 4; usg_pri = 4;
        mem_vld = 1; step(1);
        chk("R2 hf_req", hf_req, 1);
        chk("R2 forced", hf_stat[1], 1);
        step(1);
        // R11 enables, R9 clears
        wr(3'd0, 8'h07);
        chk("R11 flt_en", flt_en, 7);
        wr(3'd2, 8'h00);
        chk("R9 zero keeps", mem_stat, 1);
        wr(3'd2, 8'h01);
        chk("R9 one clears", mem_stat, 0);
        wr(3'd4, 8'h03);

        // R3 equal running priority escalates, R5 less urgent runs
        run_vld = 1; cur_pri = 4;
        bus_vld = 1; bus_cause = 1; step(1);
        chk("R3 hf_req", hf_req, 1);
        step(2);
        cur_pri = 5;
        bus_vld = 1; bus_cause = 2; step(1);
        chk("R5 no hard", hf_req, 0);
        step(1);
        chk("R5 fault_req", fault_req, 1);
        chk("R5 type bus", fault_type, 1);
        chk("R7 bus causes", bus_stat, 5'b00110);
        run_vld = 0; step(1);

        // R4 arrival holds pending usage fault
        arr_vld = 1; arr_pri = 1; usg_pri = 3;
        usg_vld = 1; usg_cause = 0; step(1);
        chk("R4 no hard", hf_req, 0);
        step(3);
        chk("R4 held", fault_req, 0);
        arr_vld = 0; step(1);
        chk("R4 released", fault_req, 1);
        chk("R4 type usage", fault_type, 2);
        step(1);

        // R6 vector fetch error
        vec_err = 1; step(1);
        chk("R6 hf_req", hf_req, 1);
        chk("R6 vector bit", hf_stat[0], 1);
        chk("R6 bus bit4", bus_stat[4], 1);
        step(1);

        // R8 trap gating
        wr(3'd3, 8'h7f);
        usg_vld = 1; usg_cause = 5; step(1);
        chk("R8 div0 ignored", usg_stat, 0);
        chk("R8 no hard", hf_req, 0);
        step(1);
        chk("R8 no request", fault_req, 0);
        usg_vld = 1; usg_cause = 7; step(2);
        chk("R8 code7 ignored", usg_stat, 0);
        div0_trap = 1; unal_trap = 1;
        usg_vld = 1; usg_cause = 5; step(1);
        usg_vld = 1; usg_cause = 6; step(3);
        chk("R8 traps on", usg_stat, 7'h60);

        // R10 simultaneous strobes, take order
        mem_vld = 1; bus_vld = 1; bus_cause = 3; usg_vld = 1; usg_cause = 4; step(2);
        chk("R10 first mem", fault_type, 0);
        step(1);
        chk("R10 then bus", fault_type, 1);
        step(1);
        chk("R10 then usage", fault_type, 2);
        step(1);
        wr(3'd0, 8'h06);
        mem_vld = 1; bus_vld = 1; step(1);
        chk("R10 hard first", hf_req, 1);
        step(1);
        chk("R10 bus after", fault_req, 1);
        step(2);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            if (i % 16 == 0) begin
                mem_pri = 4'($urandom); bus_pri = 4'($urandom); usg_pri = 4'($urandom);
                cur_pri = 4'($urandom); run_vld = 1'($urandom);
                div0_trap = 1'($urandom); unal_trap = 1'($urandom);
            end
            arr_vld = ($urandom % 4 == 0); arr_pri = 4'($urandom);
            mem_vld = ($urandom % 8 == 0);
            bus_vld = ($urandom % 8 == 0); bus_cause = 2'($urandom);
            usg_vld = ($urandom % 8 == 0); usg_cause = 3'($urandom);
            vec_err = ($urandom % 40 == 0);
            wr_en = ($urandom % 6 == 0); wr_sel = 3'($urandom % 5); wr_data = 8'($urandom);
            @(negedge clk);
        end
        idle(); arr_vld = 0; run_vld = 0;
        step(4);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule